// File: doc/BRIEF.md
# Home-Node Atomic Read-Modify-Write Engine

This block sits at the home node of a memory region and performs atomic read-modify-write operations for remote requesters. A requester sends a single request with an opcode, a word address, a data operand, a compare operand and a tag. The engine reads the word from its local backing store, computes the new value and writes it back. It then returns the value held before the update in one response that carries the same tag. The line never travels to the requester, so the requester never has to own it.

Requests enter a small in-order queue through a valid/ready handshake. The engine takes them from the head one at a time and completes each read-compute-write in a single cycle. When several requesters target the same hot word, their requests wait in the queue and are applied back to back, with no retries. A response waits in the output register until the requester accepts it. While it waits, no further operation starts, and the queue absorbs new arrivals until it is full.

Top module: `hn_atomic_engine`

## Requirements
- R1: After reset `resp_valid` is 0, `req_ready` is 1, and every word of the 64-word store reads as zero.
- R2: Opcode 2'b00 (fetch-add) writes old+operand, wrapping modulo 2^32, and responds with the old value.
- R3: Opcode 2'b01 (swap) writes the operand and responds with the old value.
- R4: Opcode 2'b10 (compare-and-swap) writes the operand only when the old value equals the compare operand, and responds with the old value in both cases.
- R5: Opcode 2'b11 (load) responds with the stored value and leaves the store unchanged.
- R6: Every response carries the tag of the request it answers.
- R7: Requests are executed and answered strictly in acceptance order, one at a time. A burst to one word therefore sees each earlier update.
- R8: While `resp_valid` is high and `resp_ready` is low, the response holds its data and tag. Once the queue holds 4 waiting requests, `req_ready` is low.
- R9: Each of the 64 addresses is a separate word. An update to one address does not change any other.
- R10: A request accepted on a clock edge produces its response one edge later when the output is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can accept a request |
| req_op | input | 2 | Opcode: 00 add, 01 swap, 10 compare-and-swap, 11 load |
| req_addr | input | 6 | Word address in the backing store |
| req_data | input | 32 | Addend or new value |
| req_cmp | input | 32 | Compare operand for compare-and-swap |
| req_tag | input | 4 | Requester tag, echoed in the response |
| resp_valid | output | 1 | Response available |
| resp_ready | input | 1 | Requester accepts the response |
| resp_data | output | 32 | Value held before the operation |
| resp_tag | output | 4 | Tag of the answered request |

## Verification
The bench runs a burst of five fetch-adds to one word while the response path is stalled. A design that reordered the queue, or started a second operation before the first was consumed, would return the old values out of sequence or skip an increment. A design that lost a queued entry would fail the same check. Compare-and-swap is tried both with a matching and with a mismatching compare value, and the word is read back afterwards. This catches an engine that writes on mismatch or returns the new value instead of the old one. Other checks cover the wrap of fetch-add at 2^32, the words at addresses 0 and 63 (an aliasing address decode shows up there), and a held response. A held response whose data drifts while `resp_ready` is low, or a `req_ready` that stays high when the queue is full, is also reported.

// File: rtl/hn_atomic_engine.sv
module hn_atomic_engine #(
  parameter int DW    = 32,
  parameter int AW    = 6,
  parameter int DEPTH = 4,
  parameter int TW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [DW-1:0] req_cmp,
  input  logic [TW-1:0] req_tag,
  output logic          resp_valid,
  input  logic          resp_ready,
  output logic [DW-1:0] resp_data,
  output logic [TW-1:0] resp_tag
);
  localparam int WORDS = 1 << AW;
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int EW    = 2 + AW + 2 * DW + TW;
  localparam logic [1:0] OP_ADD = 2'b00;
  localparam logic [1:0] OP_SWP = 2'b01;
  localparam logic [1:0] OP_CAS = 2'b10;

  logic [EW-1:0] q [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [DW-1:0] mem [WORDS];

  logic          push, issue;
  logic [1:0]    h_op;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_data, h_cmp, old, nxt;
  logic [TW-1:0] h_tag;
  logic          wen;

  assign req_ready = count != CW'(DEPTH);
  assign push      = req_valid && req_ready;
  assign issue     = (count != '0) && (!resp_valid || resp_ready);
  assign {h_op, h_addr, h_data, h_cmp, h_tag} = q[rd_ptr];
  assign old       = mem[h_addr];

  always_comb begin
    nxt = old;
    wen = 1'b0;
    case (h_op)
      OP_ADD: begin nxt = old + h_data; wen = 1'b1; end
      OP_SWP: begin nxt = h_data;       wen = 1'b1; end
      OP_CAS: begin nxt = h_data;       wen = (old == h_cmp); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) q[wr_ptr] <= {req_op, req_addr, req_data, req_cmp, req_tag};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)  wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (issue) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, issue})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (issue && wen) begin
      mem[h_addr] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
      resp_tag   <= '0;
    end else if (issue) begin
      resp_valid <= 1'b1;
      resp_data  <= old;
      resp_tag   <= h_tag;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_data) && $stable(resp_tag)); // R8
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    count == CW'(DEPTH) |-> !req_ready); // R8
  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    issue && h_op == OP_ADD |=> mem[$past(h_addr)] == $past(old) + $past(h_data)); // R2
  AST_CAS_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    issue && h_op == OP_CAS && old != h_cmp |=> mem[$past(h_addr)] == $past(old)); // R4
  AST_LOAD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    issue && h_op == 2'b11 |=> mem[$past(h_addr)] == $past(old)); // R5
  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |-> !issue); // R7
  AST_PROMPT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    push && count == '0 && (!resp_valid || resp_ready) |=> issue); // R10
endmodule

// File: tb/hn_atomic_engine_tb.sv
module hn_atomic_engine_tb;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, resp_ready = 1;
  logic        req_ready, resp_valid;
  logic [1:0]  req_op = 0;
  logic [5:0]  req_addr = 0;
  logic [31:0] req_data = 0, req_cmp = 0, resp_data;
  logic [3:0]  req_tag = 0, resp_tag;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  hn_atomic_engine u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_cmp(req_cmp),
    .req_tag(req_tag), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_data(resp_data), .resp_tag(resp_tag));

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic push(logic [1:0] op, logic [5:0] a, logic [31:0] d, logic [31:0] c, logic [3:0] t);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_data = d; req_cmp = c; req_tag = t;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic run_op(string r, logic [1:0] op, logic [5:0] a, logic [31:0] d,
                        logic [31:0] c, logic [3:0] t, logic [31:0] exp);
    int waited = 0;
    push(op, a, d, c, t);
    while (!resp_valid && waited < 20) begin @(negedge clk); waited++; end
    check({r, " data"}, resp_data, exp);
    check("R6 tag", {28'd0, resp_tag}, {28'd0, t});
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 resp_valid", {31'd0, resp_valid}, 0);
    check("R1 req_ready", {31'd0, req_ready}, 1);
    run_op("R1 load zero", 2'b11, 6'd5, 0, 0, 4'h1, 32'h0);
  endtask

  task automatic t_latency;
    push(2'b11, 6'd7, 0, 0, 4'h2);
    check("R10 resp after one edge", {31'd0, resp_valid}, 0);
    @(negedge clk);
    check("R10 resp valid", {31'd0, resp_valid}, 1);
    @(negedge clk);
  endtask

  task automatic t_add;
    run_op("R2 add first", 2'b00, 6'd3, 32'd10, 0, 4'h3, 32'd0);
    run_op("R2 add second", 2'b00, 6'd3, 32'd5, 0, 4'h4, 32'd10);
    run_op("R5 load after add", 2'b11, 6'd3, 32'hDEAD, 0, 4'h5, 32'd15);
    run_op("R5 load unchanged", 2'b11, 6'd3, 0, 0, 4'h6, 32'd15);
    run_op("R3 swap", 2'b01, 6'd3, 32'hFFFFFFFF, 0, 4'h7, 32'd15);
    run_op("R2 add wrap", 2'b00, 6'd3, 32'd2, 0, 4'h8, 32'hFFFFFFFF);
    run_op("R2 wrapped value", 2'b11, 6'd3, 0, 0, 4'h9, 32'd1);
  endtask

  task automatic t_cas;
    run_op("R3 swap set", 2'b01, 6'd9, 32'h1234, 0, 4'hA, 32'd0);
    run_op("R4 cas miss", 2'b10, 6'd9, 32'hAAAA, 32'h1, 4'hB, 32'h1234);
    run_op("R4 cas miss kept", 2'b11, 6'd9, 0, 0, 4'hC, 32'h1234);
    run_op("R4 cas hit", 2'b10, 6'd9, 32'hBBBB, 32'h1234, 4'hD, 32'h1234);
    run_op("R4 cas hit stored", 2'b11, 6'd9, 0, 0, 4'hE, 32'hBBBB);
  endtask

  task automatic t_alias;
    run_op("R9 write top", 2'b01, 6'd63, 32'h63, 0, 4'h1, 32'd0);
    run_op("R9 bottom untouched", 2'b11, 6'd0, 0, 0, 4'h2, 32'd0);
    run_op("R9 write bottom", 2'b01, 6'd0, 32'h11, 0, 4'h3, 32'd0);
    run_op("R9 top kept", 2'b11, 6'd63, 0, 0, 4'h4, 32'h63);
  endtask

  task automatic t_burst;
    logic [31:0] held;
    int got = 0, guard = 0;
    resp_ready = 0;
    for (int i = 0; i < 5; i++) push(2'b00, 6'd20, 32'd1, 0, 4'(i + 1));
    check("R8 ready low when full", {31'd0, req_ready}, 0);
    held = resp_data;
    @(negedge clk); @(negedge clk);
    check("R8 held data", resp_data, held);
    check("R8 held tag", {28'd0, resp_tag}, 32'd1);
    check("R7 first result", resp_data, 32'd0);
    resp_ready = 1;
    while (got < 5 && guard < 40) begin
      if (resp_valid) begin
        check("R7 burst order data", resp_data, 32'(got));
        check("R7 burst order tag", {28'd0, resp_tag}, 32'(got + 1));
        got++;
      end
      guard++;
      @(negedge clk);
    end
    check("R7 burst count", 32'(got), 32'd5);
    run_op("R7 burst total", 2'b11, 6'd20, 0, 0, 4'hF, 32'd5);
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_latency;
    t_add;
    t_cas;
    t_alias;
    t_burst;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule